// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a memory-mapped watchdog peripheral on a simple synchronous register bus. The bus carries an address, a write strobe, write data and registered read data. A 32-bit counter counts down from a programmed load value, at one step per clock while it is enabled.

When the counter reaches zero the first time, the block raises a level interrupt and reloads the counter. Software normally answers by writing the clear register. That write drops the interrupt and restarts the count, which makes it the keepalive. If the counter reaches zero again while the interrupt is still pending, and reset generation is enabled, the block emits a one-cycle system reset request. The full time to reset is therefore two counter periods.

A key register protects the configuration. Only the key value unlocks it, and any other value written there locks it again. While the block is locked, writes to every other register are dropped. Reads are always allowed.

Top module: `wdg_top`

## Requirements
- R1: After reset the block is in this state:
  - locked, so the lock register at 0xC00 reads 1;
  - load (0x000) and count (0x004) both read 0xFFFFFFFF;
  - control (0x008) reads 0 and status (0x014) reads 0;
  - irq_o and rst_req_o are low.
- R2: Writing 0x1ACCE551 to 0xC00 unlocks the block, and 0xC00 then reads 0. Writing any other value to 0xC00 locks it, and 0xC00 then reads 1.
- R3: While the block is locked, writes to 0x000, 0x008 and 0x00C have no effect. Reads still return the register contents.
- R4: An unlocked write to 0x000 sets the load value and also loads the counter with that value at once. Read data appears on bus_rdata one cycle after the address is presented.
- R5: Control bit 0 enables counting, and the counter then decrements by one per clock. While bit 0 is clear the counter holds its value. Control bits 31:2 read as zero.
- R6: When the counter is enabled and at zero, the next clock reloads the counter from the load value and sets the interrupt if it is not already set. irq_o follows the status bit, and 0x014 reads 1 while the interrupt is pending. With load value N, the first expiry sets irq_o N+1 clocks after the enabling write.
- R7: An unlocked write of any value to 0x00C clears the interrupt and reloads the counter from the load value on the next clock.
- R8: When an expiry occurs while the interrupt is still set and control bit 1 is set, rst_req_o goes high for exactly one clock and the interrupt clears.
- R9: When an expiry occurs while the interrupt is still set and control bit 1 is clear, rst_req_o stays low and the interrupt stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_o | output | 1 | Interrupt level, high while the first-stage expiry is pending |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
A wrong lock state shows at the ports within two cycles, either through the lock register read or through a configuration write that does or does not land. A counter that is off by one shifts the cycle in which irq_o rises, so the bench checks the exact edge. A wrong interrupt state shows at the next expiry as a missing or extra reset pulse, which is at most one load period later. The sequence of a keepalive followed by a further expiry tells a genuine reload apart from a stuck count.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned OFF_LOAD   = 32'h000;
  localparam int unsigned OFF_COUNT  = 32'h004;
  localparam int unsigned OFF_CTRL   = 32'h008;
  localparam int unsigned OFF_CLEAR  = 32'h00C;
  localparam int unsigned OFF_STATUS = 32'h014;
  localparam int unsigned OFF_LOCK   = 32'hC00;
  localparam int unsigned CTRL_RUN_BIT = 0;
  localparam int unsigned CTRL_RST_BIT = 1;
  localparam logic [31:0] DEFAULT_KEY = 32'h1ACCE551;
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter logic [DATA_W-1:0] KEY = DATA_W'(DEFAULT_KEY)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              irq_lvl,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CNT_W-1:0]  load_q,
  output logic              run_q,
  output logic              rst_en_q,
  output logic              load_wr,
  output logic              kick
);
  localparam logic [ADDR_W-1:0] A_LOAD   = ADDR_W'(OFF_LOAD);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFF_COUNT);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFF_CLEAR);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_LOCK   = ADDR_W'(OFF_LOCK);

  logic open_q;
  logic wr_ok;

  assign wr_ok   = bus_we && open_q;
  assign load_wr = wr_ok && (bus_addr == A_LOAD);
  assign kick    = wr_ok && (bus_addr == A_CLEAR);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q   <= 1'b0;
      load_q   <= '1;
      run_q    <= 1'b0;
      rst_en_q <= 1'b0;
    end else begin
      if (bus_we && (bus_addr == A_LOCK))
        open_q <= (bus_wdata == KEY);
      if (load_wr)
        load_q <= CNT_W'(bus_wdata);
      if (wr_ok && (bus_addr == A_CTRL)) begin
        run_q    <= bus_wdata[CTRL_RUN_BIT];
        rst_en_q <= bus_wdata[CTRL_RST_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      case (bus_addr)
        A_LOAD:   bus_rdata <= DATA_W'(load_q);
        A_COUNT:  bus_rdata <= DATA_W'(cnt_val);
        A_CTRL: begin
          bus_rdata[CTRL_RUN_BIT] <= run_q;
          bus_rdata[CTRL_RST_BIT] <= rst_en_q;
        end
        A_STATUS: bus_rdata <= DATA_W'(irq_lvl);
        A_LOCK:   bus_rdata <= DATA_W'(!open_q);
        default:  bus_rdata <= '0;
      endcase
    end
  end

  // R3
  locked_load_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !open_q && bus_addr == A_LOAD) |=> $stable(load_q));
  // R3
  locked_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !open_q && bus_addr == A_CTRL) |=> ($stable(run_q) && $stable(rst_en_q)));
  // R2
  unlock_key_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_LOCK && bus_wdata == KEY) |=> open_q);
  // R2
  relock_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_LOCK && bus_wdata != KEY) |=> !open_q);
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             rst_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_wdata,
  input  logic             kick,
  output logic [CNT_W-1:0] count,
  output logic             irq,
  output logic             rst_pulse
);
  logic expire;
  assign expire = run && (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '1;
      irq       <= 1'b0;
      rst_pulse <= 1'b0;
    end else begin
      rst_pulse <= 1'b0;
      if (kick) begin
        count <= load_val;
        irq   <= 1'b0;
      end else begin
        if (load_wr)      count <= load_wdata;
        else if (expire)  count <= load_val;
        else if (run)     count <= count - CNT_W'(1);
        if (expire) begin
          if (!irq) begin
            irq <= 1'b1;
          end else if (rst_en) begin
            rst_pulse <= 1'b1;
            irq       <= 1'b0;
          end
        end
      end
    end
  end

  // R5
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !kick && !load_wr && count != '0) |=> (count == $past(count) - CNT_W'(1)));
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !kick && !load_wr) |=> $stable(count));
  // R6
  expire_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (expire && !kick && !load_wr) |=> (count == $past(load_val)));
  // R7
  kick_chk: assert property (@(posedge clk) disable iff (rst)
    kick |=> (!irq && count == $past(load_val)));
  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    rst_pulse |=> !rst_pulse);
  // R9
  rst_gate_chk: assert property (@(posedge clk) disable iff (rst)
    rst_pulse |-> ($past(rst_en) && $past(irq)));
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter logic [DATA_W-1:0] KEY = DATA_W'(DEFAULT_KEY)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] cnt_val;
  logic             run_q;
  logic             rst_en_q;
  logic             load_wr;
  logic             kick;
  logic             irq_lvl;
  logic             rst_pulse;

  wdg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .KEY(KEY)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .cnt_val(cnt_val), .irq_lvl(irq_lvl),
    .bus_rdata(bus_rdata), .load_q(load_q),
    .run_q(run_q), .rst_en_q(rst_en_q),
    .load_wr(load_wr), .kick(kick)
  );

  wdg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst),
    .run(run_q), .rst_en(rst_en_q),
    .load_val(load_q), .load_wr(load_wr),
    .load_wdata(CNT_W'(bus_wdata)), .kick(kick),
    .count(cnt_val), .irq(irq_lvl), .rst_pulse(rst_pulse)
  );

  assign irq_o     = irq_lvl;
  assign rst_req_o = rst_pulse;

  // R8
  req_needs_irq_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req_o) |-> $fell(irq_o));
endmodule

// File: tb/sim_wdg_top.sv
module sim_wdg_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic        rst_req_o;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [31:0] KEY = 32'h1ACCE551;

  always #10 clk = ~clk;

  wdg_top u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    do_reset();
    rd(12'hC00, v); check("R1 lock", v, 32'h1);
    rd(12'h000, v); check("R1 load", v, 32'hFFFFFFFF);
    rd(12'h004, v); check("R1 count", v, 32'hFFFFFFFF);
    rd(12'h008, v); check("R1 ctrl", v, 32'h0);
    rd(12'h014, v); check("R1 status", v, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 rstreq", {31'b0, rst_req_o}, 32'h0);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    do_reset();
    wr(12'h000, 32'd10);
    rd(12'h000, v); check("R3 load ignored", v, 32'hFFFFFFFF);
    wr(12'h008, 32'h1);
    rd(12'h008, v); check("R3 ctrl ignored", v, 32'h0);
    wr(12'hC00, KEY);
    rd(12'hC00, v); check("R2 unlocked", v, 32'h0);
    wr(12'h000, 32'd10);
    rd(12'h000, v); check("R4 load", v, 32'd10);
    rd(12'h004, v); check("R4 count", v, 32'd10);
    wr(12'hC00, 32'h12345678);
    rd(12'hC00, v); check("R2 relocked", v, 32'h1);
    wr(12'h000, 32'd77);
    rd(12'h000, v); check("R3 load ignored after relock", v, 32'd10);
  endtask

  task automatic t_count();
    logic [31:0] v;
    do_reset();
    wr(12'hC00, KEY);
    wr(12'h008, 32'hFFFFFFFF);
    rd(12'h008, v); check("R5 reserved bits", v, 32'h3);
    wr(12'h008, 32'h0);
    wr(12'h000, 32'd100);
    wr(12'h008, 32'h1);
    repeat (10) @(negedge clk);
    wr(12'h008, 32'h0);
    repeat (3) @(negedge clk);
    rd(12'h004, v); check("R5 count after 11 steps", v, 32'd89);
    repeat (5) @(negedge clk);
    rd(12'h004, v); check("R5 count held", v, 32'd89);
  endtask

  task automatic t_two_stage();
    logic [31:0] v;
    do_reset();
    wr(12'hC00, KEY);
    wr(12'h000, 32'd5);
    wr(12'h008, 32'h3);
    repeat (5) @(negedge clk);
    check("R6 irq before expiry", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    check("R6 irq at expiry", {31'b0, irq_o}, 32'h1);
    rd(12'h014, v); check("R6 status", v, 32'h1);
    repeat (4) @(negedge clk);
    check("R8 no early reset", {31'b0, rst_req_o}, 32'h0);
    check("R8 irq still pending", {31'b0, irq_o}, 32'h1);
    @(negedge clk);
    check("R8 reset pulse", {31'b0, rst_req_o}, 32'h1);
    check("R8 irq cleared", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    check("R8 pulse one cycle", {31'b0, rst_req_o}, 32'h0);
  endtask

  task automatic t_no_reset();
    logic [31:0] v;
    int seen;
    do_reset();
    wr(12'hC00, KEY);
    wr(12'h000, 32'd3);
    wr(12'h008, 32'h1);
    seen = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (rst_req_o) seen++;
    end
    check("R9 no reset pulse", seen, 0);
    check("R9 irq held", {31'b0, irq_o}, 32'h1);
    rd(12'h014, v); check("R9 status", v, 32'h1);
  endtask

  task automatic t_kick();
    int seen;
    do_reset();
    wr(12'hC00, KEY);
    wr(12'h000, 32'd4);
    wr(12'h008, 32'h3);
    repeat (5) @(negedge clk);
    check("R7 irq set", {31'b0, irq_o}, 32'h1);
    wr(12'h00C, 32'h1);
    check("R7 irq cleared", {31'b0, irq_o}, 32'h0);
    seen = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (rst_req_o) seen++;
    end
    check("R7 reload gives full period, no reset", seen, 0);
    check("R7 irq after reload period", {31'b0, irq_o}, 32'h1);
    wr(12'hC00, 32'h0);
    wr(12'h00C, 32'h1);
    check("R3 clear ignored while locked", {31'b0, irq_o}, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_lock();
    t_count();
    t_two_stage();
    t_no_reset();
    t_kick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule